// File: doc/BRIEF.md
# Reduction Variable Access Monitor

This block sits beside a core's load-store queue during speculative loop execution and watches a small table of registered reduction variables. Software registers a variable with a pair command giving the shared variable's address, the address of the core's private partial copy, the combining operator and the data type. It removes the variable again with an unpair command that names the shared address.

Every load or store presented by the queue is first screened against a 16-bit address signature and then compared exactly against the valid table entries. On a match the block stalls the queue in the same cycle. It waits until the external "earlier iterations done" level is high, then runs a fix-up over a simple one-cycle-latency memory port. For a load it reads the private copy and the shared variable, writes back their combination, and resets the private copy to the operator's identity. For a store it only resets the private copy. It then drops the stall for one cycle so that the held access proceeds.

Top module: `redvar_monitor`

## Requirements
- R1: A pair command with operator code 0 (add), 1 (OR) or 2 (AND), data type code 0 (32-bit integer) and a free slot is accepted without error, and a later load or store to that shared address raises `lsq_stall` in the cycle it is presented.
- R2: A pair command that arrives while all 4 entries are valid raises `cmd_err` for one cycle, in the cycle after the command, and allocates nothing: an access to its address is not stalled.
- R3: A pair command with operator code 3 or a data type code other than 0 is rejected with `cmd_err` and allocates nothing.
- R4: Unpair frees the entry whose shared address matches, so later accesses to it are not stalled. Unpairing an address that is not in the table has no effect and raises no error.
- R5: After reset, and for any access whose address matches no valid entry, `lsq_stall` stays low and no memory request is made.
- R6: On a hit `lsq_stall` stays high from the first cycle until the fix-up's last write is issued. It is then low for one cycle in which the held access passes. With the earlier-iterations input already high, a load is stalled for 8 cycles and a store for 3.
- R7: No memory request is made until `prior_done` has been seen high during the stall. The stall holds for as long as `prior_done` stays low.
- R8: A load hit reads the private copy, then reads the shared variable, then writes the shared variable with (shared op private), then writes the private copy with the identity value: 2 reads and 2 writes.
- R9: A store hit performs no read. It writes only the private copy, with the identity value, and leaves the shared variable to the store itself.
- R10: The combining results and identities are: add gives a sum modulo 2^32 with identity 0; OR gives a bitwise OR with identity 0; AND gives a bitwise AND with identity 0xFFFFFFFF.
- R11: The signature never misses. An address matching a valid entry always finds its signature bit set. The bit is the XOR of the 4-bit groups of the word address (address bits 31:2). A signature-only false hit causes no stall.
- R12: A slot freed by unpair can be allocated again by a new pair command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_pair | input | 1 | 1 = pair, 0 = unpair |
| cmd_shared_addr | input | 32 | Shared variable address (both commands) |
| cmd_priv_addr | input | 32 | Private copy address (pair only) |
| cmd_op | input | 2 | Operator: 0 add, 1 OR, 2 AND |
| cmd_dtype | input | 2 | Data type: 0 = 32-bit integer |
| cmd_err | output | 1 | Pair rejected, one cycle after the command |
| lsq_valid | input | 1 | Queue presents an access |
| lsq_store | input | 1 | 1 = store, 0 = load |
| lsq_addr | input | 32 | Access address |
| lsq_stall | output | 1 | Hold the presented access |
| prior_done | input | 1 | Earlier iterations have finished their updates |
| mem_req | output | 1 | Fix-up memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid, one cycle after a read request |

## Verification
The checks assume that the queue keeps an access presented, with the same address and kind, for as long as `lsq_stall` is high. They also assume that the memory answers each read with `mem_rvalid` exactly one cycle later and never otherwise. The bench holds `lsq_valid` steady until it sees the stall drop, and drops it within the release cycle. Its memory model registers each read and replies on the next cycle only. Commands are never issued during an access, so that the table state each scenario expects is fixed before the access begins.

// File: rtl/redvar_pkg.sv
package redvar_pkg;

    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int SIG_W     = 16;
    localparam int SIG_IDX_W = $clog2(SIG_W);
    localparam int HASH_GRPS = ADDR_W / SIG_IDX_W;

    localparam logic [1:0] DT_I32 = 2'd0;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_OR  = 2'd1,
        OP_AND = 2'd2,
        OP_BAD = 2'd3
    } red_op_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] shared;
        logic [ADDR_W-1:0] priv;
        red_op_e           op;
    } red_ent_t;

    typedef enum logic [3:0] {
        FX_IDLE,
        FX_WAIT_PRIOR,
        FX_RD_PRIV,
        FX_WT_PRIV,
        FX_RD_SHARED,
        FX_WT_SHARED,
        FX_WR_SHARED,
        FX_WR_PRIV,
        FX_RELEASE
    } fx_state_e;

    // Signature bit index: XOR of the groups of the word address
    function automatic logic [SIG_IDX_W-1:0] sig_index(input logic [ADDR_W-1:0] addr);
        logic [ADDR_W-1:0]    word;
        logic [SIG_IDX_W-1:0] h;
        word = addr >> 2;
        h    = '0;
        for (int g = 0; g < HASH_GRPS; g++) begin
            h ^= word[g*SIG_IDX_W +: SIG_IDX_W];
        end
        return h;
    endfunction

    function automatic logic [DATA_W-1:0] op_identity(input red_op_e op);
        case (op)
            OP_AND:  return '1;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] op_combine(input red_op_e op,
                                                     input logic [DATA_W-1:0] a,
                                                     input logic [DATA_W-1:0] b);
        case (op)
            OP_OR:   return a | b;
            OP_AND:  return a & b;
            default: return a + b;
        endcase
    endfunction

endpackage

// File: rtl/redvar_table.sv
module redvar_table
    import redvar_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_pair,
    input  logic [ADDR_W-1:0] cmd_shared,
    input  logic [ADDR_W-1:0] cmd_priv,
    input  logic [1:0]        cmd_op,
    input  logic [1:0]        cmd_dtype,
    output logic              pair_ok,
    output logic [N_ENT-1:0]  free_vec,
    output logic              cmd_err,
    output logic [N_ENT-1:0]  ent_valid,
    output logic [ADDR_W-1:0] ent_shared [N_ENT],
    output logic [ADDR_W-1:0] ent_priv   [N_ENT],
    output red_op_e           ent_op     [N_ENT]
);

    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    red_ent_t          ent_q [N_ENT];
    logic              full;
    logic              pair_bad;
    logic              is_pair;
    logic [IDX_W-1:0]  slot;
    logic              slot_found;

    assign is_pair = cmd_valid && cmd_pair;
    assign full    = &ent_valid;

    always_comb begin
        slot       = '0;
        slot_found = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (!ent_q[i].valid && !slot_found) begin
                slot       = IDX_W'(i);
                slot_found = 1'b1;
            end
        end
    end

    assign pair_bad = is_pair && (full || (red_op_e'(cmd_op) == OP_BAD) || (cmd_dtype != DT_I32));
    assign pair_ok  = is_pair && !pair_bad;

    generate
        for (genvar i = 0; i < N_ENT; i++) begin : g_ent
            assign free_vec[i]   = cmd_valid && !cmd_pair && ent_q[i].valid &&
                                   (ent_q[i].shared == cmd_shared);
            assign ent_valid[i]  = ent_q[i].valid;
            assign ent_shared[i] = ent_q[i].shared;
            assign ent_priv[i]   = ent_q[i].priv;
            assign ent_op[i]     = ent_q[i].op;

            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_q[i] <= '0;
                end else if (pair_ok && (slot == IDX_W'(i))) begin
                    ent_q[i].valid  <= 1'b1;
                    ent_q[i].shared <= cmd_shared;
                    ent_q[i].priv   <= cmd_priv;
                    ent_q[i].op     <= red_op_e'(cmd_op);
                end else if (free_vec[i]) begin
                    ent_q[i].valid <= 1'b0;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_err <= 1'b0;
        end else begin
            cmd_err <= pair_bad;
        end
    end

    AST_ERR_FROM_PAIR: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $past(cmd_valid && cmd_pair)); // R2
    AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
        (is_pair && full) |=> $stable(ent_valid)); // R2
    AST_UNPAIR_NO_GROW: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_pair) |=> ($countones(ent_valid) <= $past($countones(ent_valid)))); // R4

endmodule

// File: rtl/redvar_sig.sv
module redvar_sig
    import redvar_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pair_ok,
    input  logic [ADDR_W-1:0] pair_addr,
    input  logic [N_ENT-1:0]  free_vec,
    input  logic [N_ENT-1:0]  ent_valid,
    input  logic [ADDR_W-1:0] ent_shared [N_ENT],
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              sig_hit
);

    logic [SIG_W-1:0] sig_q;
    logic [SIG_W-1:0] rebuilt;
    logic [SIG_W-1:0] sig_d;

    // Rebuild from the entries that survive this unpair
    always_comb begin
        rebuilt = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (ent_valid[i] && !free_vec[i]) begin
                rebuilt |= SIG_W'(1) << sig_index(ent_shared[i]);
            end
        end
    end

    always_comb begin
        if (pair_ok) begin
            sig_d = sig_q | (SIG_W'(1) << sig_index(pair_addr));
        end else if (|free_vec) begin
            sig_d = rebuilt;
        end else begin
            sig_d = sig_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_q <= '0;
        end else begin
            sig_q <= sig_d;
        end
    end

    assign sig_hit = sig_q[sig_index(probe_addr)];

endmodule

// File: rtl/redvar_fixup.sv
module redvar_fixup
    import redvar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              hit_store,
    input  logic [ADDR_W-1:0] hit_shared,
    input  logic [ADDR_W-1:0] hit_priv,
    input  red_op_e           hit_op,
    input  logic              prior_done,
    output logic              stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid
);

    fx_state_e         state_q;
    fx_state_e         state_d;
    logic              store_q;
    logic [ADDR_W-1:0] shared_q;
    logic [ADDR_W-1:0] priv_q;
    red_op_e           op_q;
    logic [DATA_W-1:0] pval_q;
    logic [DATA_W-1:0] sval_q;
    logic              prior_seen_q;

    always_comb begin
        state_d   = state_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            FX_IDLE: begin
                if (hit) state_d = FX_WAIT_PRIOR;
            end
            FX_WAIT_PRIOR: begin
                if (prior_done) state_d = store_q ? FX_WR_PRIV : FX_RD_PRIV;
            end
            FX_RD_PRIV: begin
                mem_req  = 1'b1;
                mem_addr = priv_q;
                state_d  = FX_WT_PRIV;
            end
            FX_WT_PRIV: begin
                if (mem_rvalid) state_d = FX_RD_SHARED;
            end
            FX_RD_SHARED: begin
                mem_req  = 1'b1;
                mem_addr = shared_q;
                state_d  = FX_WT_SHARED;
            end
            FX_WT_SHARED: begin
                if (mem_rvalid) state_d = FX_WR_SHARED;
            end
            FX_WR_SHARED: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = shared_q;
                mem_wdata = op_combine(op_q, sval_q, pval_q);
                state_d   = FX_WR_PRIV;
            end
            FX_WR_PRIV: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = priv_q;
                mem_wdata = op_identity(op_q);
                state_d   = FX_RELEASE;
            end
            FX_RELEASE: begin
                state_d = FX_IDLE;
            end
            default: state_d = FX_IDLE;
        endcase
    end

    // Hit in idle stalls at once; the release cycle lets the access pass
    assign stall = (state_q == FX_IDLE) ? hit : (state_q != FX_RELEASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= FX_IDLE;
            store_q  <= 1'b0;
            shared_q <= '0;
            priv_q   <= '0;
            op_q     <= OP_ADD;
            pval_q   <= '0;
            sval_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == FX_IDLE && hit) begin
                store_q  <= hit_store;
                shared_q <= hit_shared;
                priv_q   <= hit_priv;
                op_q     <= hit_op;
            end
            if (state_q == FX_WT_PRIV && mem_rvalid) pval_q <= mem_rdata;
            if (state_q == FX_WT_SHARED && mem_rvalid) sval_q <= mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prior_seen_q <= 1'b0;
        end else begin
            prior_seen_q <= stall && (prior_seen_q || prior_done);
        end
    end

    AST_MEM_AFTER_PRIOR: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> prior_seen_q); // R7
    AST_READ_THEN_GAP: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> !mem_req); // R8
    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        mem_rvalid |-> $past(mem_req && !mem_we)); // R8
    AST_STALL_ENDS_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> $past(mem_req && mem_we)); // R6
    AST_STORE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (store_q && state_q != FX_IDLE) |-> !(mem_req && !mem_we)); // R9

endmodule

// File: rtl/redvar_monitor.sv
module redvar_monitor
    import redvar_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_pair,
    input  logic [ADDR_W-1:0] cmd_shared_addr,
    input  logic [ADDR_W-1:0] cmd_priv_addr,
    input  logic [1:0]        cmd_op,
    input  logic [1:0]        cmd_dtype,
    output logic              cmd_err,
    input  logic              lsq_valid,
    input  logic              lsq_store,
    input  logic [ADDR_W-1:0] lsq_addr,
    output logic              lsq_stall,
    input  logic              prior_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid
);

    logic              pair_ok;
    logic [N_ENT-1:0]  free_vec;
    logic [N_ENT-1:0]  ent_valid;
    logic [ADDR_W-1:0] ent_shared [N_ENT];
    logic [ADDR_W-1:0] ent_priv   [N_ENT];
    red_op_e           ent_op     [N_ENT];
    logic              sig_hit;
    logic [N_ENT-1:0]  exact_vec;
    logic              hit;
    logic [ADDR_W-1:0] sel_shared;
    logic [ADDR_W-1:0] sel_priv;
    red_op_e           sel_op;

    redvar_table #(.N_ENT(N_ENT)) i_table (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_pair   (cmd_pair),
        .cmd_shared (cmd_shared_addr),
        .cmd_priv   (cmd_priv_addr),
        .cmd_op     (cmd_op),
        .cmd_dtype  (cmd_dtype),
        .pair_ok    (pair_ok),
        .free_vec   (free_vec),
        .cmd_err    (cmd_err),
        .ent_valid  (ent_valid),
        .ent_shared (ent_shared),
        .ent_priv   (ent_priv),
        .ent_op     (ent_op)
    );

    redvar_sig #(.N_ENT(N_ENT)) i_sig (
        .clk        (clk),
        .rst        (rst),
        .pair_ok    (pair_ok),
        .pair_addr  (cmd_shared_addr),
        .free_vec   (free_vec),
        .ent_valid  (ent_valid),
        .ent_shared (ent_shared),
        .probe_addr (lsq_addr),
        .sig_hit    (sig_hit)
    );

    generate
        for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
            assign exact_vec[i] = ent_valid[i] && (ent_shared[i] == lsq_addr);
        end
    endgenerate

    always_comb begin
        sel_shared = '0;
        sel_priv   = '0;
        sel_op     = OP_ADD;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (exact_vec[i]) begin
                sel_shared = ent_shared[i];
                sel_priv   = ent_priv[i];
                sel_op     = ent_op[i];
            end
        end
    end

    // Signature screens first; the exact compare confirms
    assign hit = lsq_valid && sig_hit && (|exact_vec);

    redvar_fixup i_fixup (
        .clk        (clk),
        .rst        (rst),
        .hit        (hit),
        .hit_store  (lsq_store),
        .hit_shared (sel_shared),
        .hit_priv   (sel_priv),
        .hit_op     (sel_op),
        .prior_done (prior_done),
        .stall      (lsq_stall),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_rvalid (mem_rvalid)
    );

    AST_SIG_NO_MISS: assert property (@(posedge clk) disable iff (rst)
        (lsq_valid && |exact_vec) |-> sig_hit); // R11
    AST_EXACT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(exact_vec)); // R1

endmodule

// File: tb/test_redvar_monitor.sv
module test_redvar_monitor;
    import redvar_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic              cmd_pair = 1'b0;
    logic [31:0]       cmd_shared_addr = '0;
    logic [31:0]       cmd_priv_addr = '0;
    logic [1:0]        cmd_op = '0;
    logic [1:0]        cmd_dtype = '0;
    logic              cmd_err;
    logic              lsq_valid = 1'b0;
    logic              lsq_store = 1'b0;
    logic [31:0]       lsq_addr = '0;
    logic              lsq_stall;
    logic              prior_done = 1'b1;
    logic              mem_req;
    logic              mem_we;
    logic [31:0]       mem_addr;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;
    logic              mem_rvalid = 1'b0;

    logic [31:0]       mem [16];
    logic              pre_we = 1'b0;
    logic [3:0]        pre_idx = '0;
    logic [31:0]       pre_data = '0;
    int                rd_cnt = 0;
    int                wr_cnt = 0;
    int                errors = 0;
    int                checks = 0;

    always #10 clk = ~clk;

    redvar_monitor i_redvar_monitor (.*);

    // Memory model: one-cycle read latency
    always @(posedge clk) begin
        mem_rvalid <= mem_req && !mem_we;
        mem_rdata  <= mem[mem_addr[5:2]];
        if (pre_we) mem[pre_idx] <= pre_data;
        else if (mem_req && mem_we) mem[mem_addr[5:2]] <= mem_wdata;
        if (mem_req && !mem_we) rd_cnt <= rd_cnt + 1;
        if (mem_req && mem_we) wr_cnt <= wr_cnt + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk);
        pre_we = 1'b1; pre_idx = addr[5:2]; pre_data = data;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic command(input logic pair, input logic [31:0] sh, input logic [31:0] pv,
                           input logic [1:0] op, input logic [1:0] dt, output logic err);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_pair = pair; cmd_shared_addr = sh;
        cmd_priv_addr = pv; cmd_op = op; cmd_dtype = dt;
        @(negedge clk);
        cmd_valid = 1'b0;
        err = cmd_err;
    endtask

    task automatic access(input logic [31:0] addr, input logic st,
                          output int stalled, output int rds, output int wrs);
        int rd0, wr0;
        @(negedge clk);
        rd0 = rd_cnt; wr0 = wr_cnt;
        lsq_valid = 1'b1; lsq_store = st; lsq_addr = addr;
        #1;
        stalled = 0;
        while (lsq_stall && stalled < 500) begin
            stalled++;
            @(negedge clk);
            #1;
        end
        lsq_valid = 1'b0;
        @(negedge clk);
        rds = rd_cnt - rd0; wrs = wr_cnt - wr0;
    endtask

    task automatic t_reset;
        check("R5 reset stall", {31'b0, lsq_stall}, 32'd0);
        check("R5 reset mem_req", {31'b0, mem_req}, 32'd0);
        check("R2 reset err", {31'b0, cmd_err}, 32'd0);
    endtask

    task automatic t_pair_all;
        logic e;
        command(1'b1, 32'h00, 32'h20, 2'd0, 2'd0, e); check("R1 pair add", {31'b0, e}, 32'd0);
        command(1'b1, 32'h04, 32'h24, 2'd1, 2'd0, e); check("R1 pair or", {31'b0, e}, 32'd0);
        command(1'b1, 32'h08, 32'h28, 2'd2, 2'd0, e); check("R1 pair and", {31'b0, e}, 32'd0);
        command(1'b1, 32'h0C, 32'h2C, 2'd0, 2'd0, e); check("R1 pair 4th", {31'b0, e}, 32'd0);
    endtask

    task automatic t_miss;
        int s, r, w;
        access(32'h44, 1'b0, s, r, w); // shares signature bit with 0x00
        check("R11 false hit no stall", s, 0);
        check("R5 miss no mem", r + w, 0);
    endtask

    task automatic t_full;
        logic e;
        int s, r, w;
        command(1'b1, 32'h10, 32'h30, 2'd0, 2'd0, e);
        check("R2 full err", {31'b0, e}, 32'd1);
        access(32'h10, 1'b0, s, r, w);
        check("R2 full no alloc", s, 0);
    endtask

    task automatic t_load_add;
        int s, r, w;
        preload(32'h00, 32'd10); preload(32'h20, 32'd5);
        access(32'h00, 1'b0, s, r, w);
        check("R6 load stall cycles", s, 8);
        check("R8 reads", r, 2);
        check("R8 writes", w, 2);
        check("R10 add result", mem[0], 32'd15);
        check("R10 add identity", mem[8], 32'd0);
    endtask

    task automatic t_load_or_and;
        int s, r, w;
        preload(32'h04, 32'h0000_0F00); preload(32'h24, 32'h0000_00F0);
        access(32'h04, 1'b0, s, r, w);
        check("R10 or result", mem[1], 32'h0000_0FF0);
        check("R10 or identity", mem[9], 32'd0);
        preload(32'h08, 32'hFF00_FF00); preload(32'h28, 32'h0FF0_0FF0);
        access(32'h08, 1'b0, s, r, w);
        check("R10 and result", mem[2], 32'h0F00_0F00);
        check("R10 and identity", mem[10], 32'hFFFF_FFFF);
    endtask

    task automatic t_store;
        int s, r, w;
        preload(32'h08, 32'h5555_0000); preload(32'h28, 32'h0000_1234);
        access(32'h08, 1'b1, s, r, w);
        check("R6 store stall cycles", s, 3);
        check("R9 store no read", r, 0);
        check("R9 store one write", w, 1);
        check("R9 priv reset", mem[10], 32'hFFFF_FFFF);
        check("R9 shared untouched", mem[2], 32'h5555_0000);
    endtask

    task automatic t_prior_wait;
        int n, r0, w0;
        preload(32'h0C, 32'd7); preload(32'h2C, 32'd3);
        @(negedge clk);
        prior_done = 1'b0;
        r0 = rd_cnt; w0 = wr_cnt;
        lsq_valid = 1'b1; lsq_store = 1'b0; lsq_addr = 32'h0C;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
        end
        #1;
        check("R7 stall held", {31'b0, lsq_stall}, 32'd1);
        check("R7 no mem before prior", rd_cnt - r0 + wr_cnt - w0, 0);
        prior_done = 1'b1;
        n = 0;
        while (lsq_stall && n < 500) begin
            n++;
            @(negedge clk);
            #1;
        end
        lsq_valid = 1'b0;
        @(negedge clk);
        check("R7 result after prior", mem[3], 32'd10);
    endtask

    task automatic t_unpair;
        logic e;
        int s, r, w;
        command(1'b0, 32'h3C, 32'h0, 2'd0, 2'd0, e);
        check("R4 unknown unpair no err", {31'b0, e}, 32'd0);
        access(32'h00, 1'b0, s, r, w);
        check("R4 unknown unpair no effect", s, 8);
        command(1'b0, 32'h04, 32'h0, 2'd0, 2'd0, e);
        access(32'h04, 1'b0, s, r, w);
        check("R4 freed no stall", s, 0);
        command(1'b1, 32'h14, 32'h30, 2'd0, 2'd0, e);
        check("R12 reuse accepted", {31'b0, e}, 32'd0);
        preload(32'h14, 32'd1); preload(32'h30, 32'd2);
        access(32'h14, 1'b0, s, r, w);
        check("R12 reuse stalls", s, 8);
        check("R12 reuse result", mem[5], 32'd3);
    endtask

    task automatic t_bad_fields;
        logic e;
        int s, r, w;
        command(1'b0, 32'h0C, 32'h0, 2'd0, 2'd0, e);
        command(1'b1, 32'h18, 32'h34, 2'd3, 2'd0, e);
        check("R3 bad op err", {31'b0, e}, 32'd1);
        access(32'h18, 1'b0, s, r, w);
        check("R3 bad op no alloc", s, 0);
        command(1'b1, 32'h18, 32'h34, 2'd0, 2'd1, e);
        check("R3 bad dtype err", {31'b0, e}, 32'd1);
        command(1'b1, 32'h18, 32'h34, 2'd1, 2'd0, e);
        check("R3 good pair after", {31'b0, e}, 32'd0);
        access(32'h18, 1'b1, s, r, w);
        check("R1 new entry stalls", s, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_pair_all();
        t_miss();
        t_full();
        t_load_add();
        t_load_or_and();
        t_store();
        t_prior_wait();
        t_unpair();
        t_bad_fields();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule